// File: doc/BRIEF.md
# Packed Per-Block Protection Table

This block holds a two-bit protection level for every flash block, four levels packed into each byte of a small table. With the default sizing it covers 256 blocks in 64 bytes. A programming sequencer raises protection by streaming one byte per table entry from a fixed scratch-RAM window. Each incoming byte is ORed into the stored byte, so a level can only move upward. A single erase-all strobe is the only way to return every level to unprotected. Erasing an individual flash block never reaches this table.

A combinational lookup port takes a block number and returns that block's stored level. It also returns four decoded permission flags, which the surrounding access logic uses to gate library reads, external reads, external writes and internal writes. Internal reads are not gated at any level, so they have no flag. While a merge pass is running, the block reports which scratch address it expects next. It pulses a done flag once the last table byte has been merged.

Top module: `prot_table`

## Requirements
- R1: After reset, every block reads level 00b with all four permission flags set, `src_addr_o` equals the scratch base (80h), and `done_o` is low.
- R2: Block b is stored in table byte b[7:2], in bit pair b[1:0]. Block 4k sits in bits 1:0 of byte k and block 4k+3 in bits 7:6. The lookup returns that pair on `lk_level_o` in the same cycle.
- R3: A byte accepted on `upd_valid_i` replaces its table byte with the bitwise OR of the old value and `upd_data_i`.
- R4: Within a pass, the k-th accepted byte (k = 0..63) goes to table byte k, and `src_addr_o` reads 80h + k while that byte is expected.
- R5: The cycle after the 64th byte is accepted, `done_o` is high for exactly one cycle, and the next pass starts again at byte 0 (`src_addr_o` = 80h).
- R6: Without an erase-all, no block's level ever loses a set bit. A pass of all-zero bytes leaves every level unchanged.
- R7: `clr_i` zeroes every level in the next cycle and restarts the pass at byte 0. When `clr_i` and `upd_valid_i` are both high in the same cycle, the clear wins and the byte is dropped.
- R8: `lk_perm_o` bits are [3] internal write, [2] external write, [1] external read, [0] library read. Levels 00b/01b/10b/11b give 1111b/1100b/1000b/0000b.
- R9: During a pass, a lookup of a block in table byte k returns the old level up to the clock edge that accepts byte k, and the merged level from that edge on.
- R10: While `upd_valid_i` and `clr_i` are both low, neither the table nor `src_addr_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Erase-all strobe, clears every level |
| upd_valid_i | input | 1 | Update byte present this cycle |
| upd_data_i | input | 8 | Update byte read from the scratch window |
| src_addr_o | output | 8 | Scratch address of the byte expected next |
| done_o | output | 1 | One-cycle pulse after the last byte of a pass |
| lk_block_i | input | 8 | Block number to look up |
| lk_level_o | output | 2 | Stored level of the looked-up block |
| lk_perm_o | output | 4 | Decoded permission flags of that block |

## Verification
The bench builds the block with its default parameters: 256 blocks, a 64-byte table, an 8-bit scratch address and a base of 80h. These values put both table ends, byte 0 and byte 63 (blocks 252 to 255), within a single full pass. They also make the 80h to BFh scratch window and the index wrap after the last byte directly observable. Under these values a stimulus table of scattered block levels can be turned into a packed byte image and read back through the lookup port. This exercises every bit-pair position and every level code.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int LVL_W  = 2;
    localparam int PERM_W = 4;

    // Permission flag positions on the lookup port
    localparam int PERM_LIB_RD = 0;
    localparam int PERM_EXT_RD = 1;
    localparam int PERM_EXT_WR = 2;
    localparam int PERM_INT_WR = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_OPEN    = 2'b00,
        LVL_NO_READ = 2'b01,
        LVL_NO_XWR  = 2'b10,
        LVL_LOCKED  = 2'b11
    } prot_lvl_e;

    // Lowest level at which a right is withdrawn
    function automatic int strip_level(input int right);
        case (right)
            PERM_LIB_RD: return int'(LVL_NO_READ);
            PERM_EXT_RD: return int'(LVL_NO_READ);
            PERM_EXT_WR: return int'(LVL_NO_XWR);
            default:     return int'(LVL_LOCKED);
        endcase
    endfunction

endpackage

// File: rtl/prot_merge_ctrl.sv
module prot_merge_ctrl #(
    parameter int                  TABLE_BYTES = 64,
    parameter int                  SADDR_W     = 8,
    parameter logic [SADDR_W-1:0]  SRC_BASE    = 8'h80,
    localparam int                 IDX_W       = $clog2(TABLE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               upd_valid_i,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [SADDR_W-1:0] src_addr_o,
    output logic               done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr_i) begin
            st_d.idx = '0;
        end else if (upd_valid_i) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o    = upd_valid_i & ~clr_i;
    assign wr_idx_o   = st_q.idx;
    assign src_addr_o = SRC_BASE + SADDR_W'(st_q.idx);
    assign done_o     = st_q.done;

endmodule

// File: rtl/prot_table_store.sv
module prot_table_store #(
    parameter int  TABLE_BYTES = 64,
    parameter int  BYTE_W      = 8,
    localparam int IDX_W       = $clog2(TABLE_BYTES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr_i,
    input  logic                                  wr_en_i,
    input  logic [IDX_W-1:0]                      wr_idx_i,
    input  logic [BYTE_W-1:0]                     wr_data_i,
    output logic [TABLE_BYTES-1:0][BYTE_W-1:0]    table_o
);

    logic [BYTE_W-1:0] tab_d [TABLE_BYTES];
    logic [BYTE_W-1:0] tab_q [TABLE_BYTES];

    for (genvar g = 0; g < TABLE_BYTES; g++) begin : g_byte
        logic hit;
        assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_comb begin
            tab_d[g] = tab_q[g];
            if (clr_i) begin
                tab_d[g] = '0;
            end else if (hit) begin
                tab_d[g] = tab_q[g] | wr_data_i;
            end
        end

        assign table_o[g] = tab_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TABLE_BYTES; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/prot_lookup.sv
module prot_lookup
    import prot_pkg::*;
#(
    parameter int  NUM_BLOCKS  = 256,
    parameter int  BYTE_W      = 8,
    localparam int PER_BYTE    = BYTE_W / LVL_W,
    localparam int TABLE_BYTES = NUM_BLOCKS / PER_BYTE,
    localparam int BLK_W       = $clog2(NUM_BLOCKS),
    localparam int SLOT_W      = $clog2(PER_BYTE),
    localparam int IDX_W       = BLK_W - SLOT_W
) (
    input  logic [TABLE_BYTES-1:0][BYTE_W-1:0] table_i,
    input  logic [BLK_W-1:0]                   blk_i,
    output logic [LVL_W-1:0]                   level_o,
    output logic [PERM_W-1:0]                  perm_o
);

    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] slot;
    logic [BYTE_W-1:0] sel;

    assign idx  = blk_i[BLK_W-1:SLOT_W];
    assign slot = blk_i[SLOT_W-1:0];

    always_comb begin
        sel     = table_i[idx];
        level_o = sel[slot*LVL_W +: LVL_W];
    end

    for (genvar r = 0; r < PERM_W; r++) begin : g_right
        localparam logic [LVL_W-1:0] THR = LVL_W'(strip_level(r));
        assign perm_o[r] = (level_o < THR);
    end

endmodule

// File: rtl/prot_table.sv
module prot_table
    import prot_pkg::*;
#(
    parameter int                 NUM_BLOCKS = 256,
    parameter int                 BYTE_W     = 8,
    parameter int                 SADDR_W    = 8,
    parameter logic [SADDR_W-1:0] SRC_BASE   = 8'h80,
    localparam int                PER_BYTE    = BYTE_W / LVL_W,
    localparam int                TABLE_BYTES = NUM_BLOCKS / PER_BYTE,
    localparam int                BLK_W       = $clog2(NUM_BLOCKS),
    localparam int                IDX_W       = $clog2(TABLE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               upd_valid_i,
    input  logic [BYTE_W-1:0]  upd_data_i,
    output logic [SADDR_W-1:0] src_addr_o,
    output logic               done_o,
    input  logic [BLK_W-1:0]   lk_block_i,
    output logic [LVL_W-1:0]   lk_level_o,
    output logic [PERM_W-1:0]  lk_perm_o
);

    logic                               wr_en;
    logic [IDX_W-1:0]                   wr_idx;
    logic [TABLE_BYTES-1:0][BYTE_W-1:0] table_bytes;

    prot_merge_ctrl #(
        .TABLE_BYTES (TABLE_BYTES),
        .SADDR_W     (SADDR_W),
        .SRC_BASE    (SRC_BASE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .upd_valid_i (upd_valid_i),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .src_addr_o  (src_addr_o),
        .done_o      (done_o)
    );

    prot_table_store #(
        .TABLE_BYTES (TABLE_BYTES),
        .BYTE_W      (BYTE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (upd_data_i),
        .table_o   (table_bytes)
    );

    prot_lookup #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BYTE_W     (BYTE_W)
    ) u_lookup (
        .table_i (table_bytes),
        .blk_i   (lk_block_i),
        .level_o (lk_level_o),
        .perm_o  (lk_perm_o)
    );

endmodule

// File: rtl/prot_table_chk.sv
module prot_table_chk #(
    parameter int                 TABLE_BYTES = 64,
    parameter int                 SADDR_W     = 8,
    parameter logic [SADDR_W-1:0] SRC_BASE    = 8'h80,
    parameter int                 BLK_W       = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic               upd_valid_i,
    input logic [SADDR_W-1:0] src_addr_o,
    input logic               done_o,
    input logic [BLK_W-1:0]   lk_block_i,
    input logic [1:0]         lk_level_o,
    input logic [3:0]         lk_perm_o
);

    localparam logic [SADDR_W-1:0] LAST_ADDR = SRC_BASE + SADDR_W'(TABLE_BYTES - 1);

    logic [SADDR_W-1:0] addr_off;
    assign addr_off = src_addr_o - SRC_BASE;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(upd_valid_i) && !$past(clr_i) && $past(src_addr_o) == LAST_ADDR));  // R5

    AST_SRC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_off) < TABLE_BYTES);  // R4

    AST_LEVEL_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lk_block_i) && !$past(clr_i)) |-> ((lk_level_o & $past(lk_level_o)) == $past(lk_level_o)));  // R6

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (lk_level_o == 2'b00 && src_addr_o == SRC_BASE));  // R7

    AST_LOCKED_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_level_o == 2'b11) |-> (lk_perm_o == 4'b0000));  // R8

    AST_OPEN_ALL_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_level_o == 2'b00) |-> (lk_perm_o == 4'b1111));  // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid_i && !clr_i) |=> ($stable(src_addr_o) && (!$stable(lk_block_i) || $stable(lk_level_o))));  // R10

endmodule

bind prot_table prot_table_chk #(
    .TABLE_BYTES (TABLE_BYTES),
    .SADDR_W     (SADDR_W),
    .SRC_BASE    (SRC_BASE),
    .BLK_W       (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .upd_valid_i (upd_valid_i),
    .src_addr_o  (src_addr_o),
    .done_o      (done_o),
    .lk_block_i  (lk_block_i),
    .lk_level_o  (lk_level_o),
    .lk_perm_o   (lk_perm_o)
);

// File: tb/tb_prot_table.sv
module tb_prot_table;

    localparam int         NB   = 256;
    localparam int         TB   = 64;
    localparam logic [7:0] BASE = 8'h80;

    typedef struct packed {
        logic [7:0] blk;
        logic [1:0] lvl;
    } vec_t;

    // Stimulus levels and expected read-back for the first pass
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   2'd1}, '{8'd1,   2'd2}, '{8'd2,   2'd3}, '{8'd3,   2'd0},
        '{8'd7,   2'd3}, '{8'd64,  2'd1}, '{8'd130, 2'd2}, '{8'd200, 2'd2},
        '{8'd253, 2'd1}, '{8'd255, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clr_i;
    logic       upd_valid_i;
    logic [7:0] upd_data_i;
    logic [7:0] src_addr_o;
    logic       done_o;
    logic [7:0] lk_block_i;
    logic [1:0] lk_level_o;
    logic [3:0] lk_perm_o;

    always #4 clk = ~clk;

    prot_table dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .upd_valid_i (upd_valid_i),
        .upd_data_i  (upd_data_i),
        .src_addr_o  (src_addr_o),
        .done_o      (done_o),
        .lk_block_i  (lk_block_i),
        .lk_level_o  (lk_level_o),
        .lk_perm_o   (lk_perm_o)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;
    logic [7:0] img [TB];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_perm(input logic [1:0] lvl);
        case (lvl)
            2'd0:    return 4'b1111;
            2'd1:    return 4'b1100;
            2'd2:    return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic look(input string req, input logic [7:0] blk, input logic [1:0] lvl);
        lk_block_i = blk;
        #1;
        check(req, 32'(lk_level_o), 32'(lvl));
        check({req, " perm"}, 32'(lk_perm_o), 32'(exp_perm(lvl)));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic run_pass();
        for (int k = 0; k < TB; k++) begin
            @(negedge clk);
            check("R4 src_addr", 32'(src_addr_o), 32'(BASE + 8'(k)));
            if (k == TB - 1) check("R5 done early", 32'(done_o), 32'd0);
            upd_valid_i = 1'b1;
            upd_data_i  = img[k];
        end
        @(negedge clk);
        upd_valid_i = 1'b0;
        check("R5 done pulse", 32'(done_o), 32'd1);
        check("R5 wrap", 32'(src_addr_o), 32'(BASE));
        @(negedge clk);
        check("R5 done falls", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        clr_i       = 1'b0;
        upd_valid_i = 1'b0;
        upd_data_i  = '0;
        lk_block_i  = '0;
        repeat (3) @(negedge clk);

        // R1 reset state
        look("R1 blk0", 8'd0, 2'd0);
        look("R1 blk255", 8'd255, 2'd0);
        check("R1 src_addr", 32'(src_addr_o), 32'(BASE));
        check("R1 done", 32'(done_o), 32'd0);
        rst_n = 1'b1;

        // Build packed image from the vector table (R2 packing)
        for (int k = 0; k < TB; k++) img[k] = '0;
        for (int v = 0; v < NV; v++)
            img[VEC[v].blk[7:2]] |= 8'(VEC[v].lvl) << (2 * VEC[v].blk[1:0]);
        run_pass();

        // R2 / R8 read-back through the lookup port
        @(negedge clk);
        for (int v = 0; v < NV; v++) look("R2 R8 vector", VEC[v].blk, VEC[v].lvl);
        look("R2 untouched blk4", 8'd4, 2'd0);

        // R6 all-zero pass changes nothing
        for (int k = 0; k < TB; k++) img[k] = 8'h00;
        run_pass();
        for (int v = 0; v < NV; v++) look("R6 zero pass", VEC[v].blk, VEC[v].lvl);

        // R3 OR merge with 02h into every byte (pair 0 gains bit 1)
        for (int k = 0; k < TB; k++) img[k] = 8'h02;
        run_pass();
        look("R3 blk0 01|10", 8'd0, 2'd3);
        look("R3 blk1 kept", 8'd1, 2'd2);
        look("R3 blk3 kept", 8'd3, 2'd0);
        look("R3 blk64", 8'd64, 2'd3);
        look("R3 blk130 kept", 8'd130, 2'd2);
        look("R3 blk252", 8'd252, 2'd2);
        look("R3 blk253 kept", 8'd253, 2'd1);

        // R9 old value until the accepting edge (block 23 = byte 5 pair 3)
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            upd_valid_i = 1'b1;
            upd_data_i  = 8'h00;
        end
        @(negedge clk);
        upd_valid_i = 1'b1;
        upd_data_i  = 8'hC0;
        look("R9 before edge", 8'd23, 2'd0);
        @(negedge clk);
        upd_valid_i = 1'b0;
        look("R9 after edge", 8'd23, 2'd3);

        // R10 idle cycles hold table and address
        repeat (5) @(negedge clk);
        check("R10 src_addr held", 32'(src_addr_o), 32'(BASE + 8'd6));
        look("R10 level held", 8'd23, 2'd3);

        // R7 clear mid-pass
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        look("R7 blk23 cleared", 8'd23, 2'd0);
        look("R7 blk255 cleared", 8'd255, 2'd0);
        check("R7 restart", 32'(src_addr_o), 32'(BASE));

        // R7 clear wins over same-cycle update
        clr_i       = 1'b1;
        upd_valid_i = 1'b1;
        upd_data_i  = 8'hFF;
        @(negedge clk);
        clr_i       = 1'b0;
        upd_valid_i = 1'b0;
        look("R7 dropped byte", 8'd0, 2'd0);
        check("R7 addr after collide", 32'(src_addr_o), 32'(BASE));

        @(negedge clk);
        finish_run();
    end

endmodule